// File: doc/BRIEF.md
# Renaming Completion Buffer Lookup

This block is a pool of physical registers that also acts as the architectural register file. There are 32 logical registers. Numbers 0 to 14 are visible in user mode. Numbers 15 to 31 are the extra copies banked for the privileged modes.

Each entry holds a value and a small tag:
- the logical register number it stands for;
- a newest-mapping flag;
- a privileged flag, set when the logical number is 15 or above;
- a value-valid flag.

When an instruction allocates a destination, the block takes the lowest-numbered free entry and makes it the newest mapping of that logical register. The flag moves off the older entry in the same cycle. Results are written back by physical index in any order, straight into the entry. Nothing is copied to a separate register file. Retirement returns entries to the free pool by index.

Each read port takes a logical register number and searches all entries at once. Only entries that carry the newest-mapping flag take part in the compare. In user mode, privileged entries have their comparators disabled as well. The port returns four things: hit, the physical index, the value-valid flag and the data. The value array is read only when the matching entry holds a valid value. Otherwise the data output keeps what it last showed.

Lookups are registered. The inputs presented in cycle t are compared against the state before that cycle's allocate, writeback and free take effect. The results appear after the clock edge that ends cycle t.

Top module: `rename_cbuf`

## Requirements
- R1: After reset every entry is free: allocReady is 1, allocIdx is 0 and every lookup returns hit=0.
- R2: An accepted allocate (allocValid=1 while allocReady=1) takes the lowest-numbered free entry, which allocIdx shows during that cycle. A lookup of that logical register in a later cycle returns hit=1, that index and ready=0.
- R3: Allocating a logical register that already has a mapping makes the new entry the only one that hits; later lookups return the new index.
- R4: A writeback by physical index, in any order with respect to allocation, marks the entry ready. Later lookups that hit it return ready=1 and the written data.
- R5: With userMode=1, a lookup of logical register 15 to 31 returns hit=0. With userMode=0 the same lookup hits.
- R6: When a lookup hits a not-ready entry, or misses, lkData holds its previous value.
- R7: When no entry is free, allocReady is 0 and an allocate request changes no mapping.
- R8: Freeing an entry by index makes it free again, so allocReady is 1 in the next cycle. A freed entry that was the newest mapping no longer hits.
- R9: A lookup with no qualifying match returns hit=0 and ready=0.
- R10: A lookup sees the state from before the allocate, writeback and free of its own cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocate request for a destination |
| allocLog | input | 5 | Logical register being renamed |
| allocReady | output | 1 | At least one entry is free |
| allocIdx | output | 6 | Entry granted to an accepted allocate |
| wbValid | input | 1 | Result writeback strobe |
| wbIdx | input | 6 | Physical entry written |
| wbData | input | 32 | Result value |
| freeValid | input | 1 | Return an entry to the free pool |
| freeIdx | input | 6 | Entry being freed |
| userMode | input | 1 | 1 limits the search to user-visible entries |
| lkLog | input | 2x5 | Logical register per read port |
| lkHit | output | 2 | Lookup found a mapping, per port |
| lkIdx | output | 2x6 | Physical index of the hit, per port |
| lkRdy | output | 2 | Hit entry holds a valid value, per port |
| lkData | output | 2x32 | Value read, held when not ready, per port |

## Verification
A lookup and an allocate of the same logical register can fall in the same cycle. So can a lookup and a writeback to the very entry it hits. The directed part of the bench forces both: it renames register 3 while both ports search for it, and it writes back entries that are being looked up in that cycle. A long pseudo-random phase then mixes allocate, writeback, free and mode changes on every cycle. Every lookup result is judged against a behavioural map table that is evaluated before that cycle's updates are applied. The judgment therefore expects the old mapping, the old ready flag and held data whenever the collision occurs.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic allocEn;
    logic freeEn;
    logic wbEn;
  } cb_strobe_t;

endpackage

// File: rtl/rcb_lookup.sv
// One read port: qualified associative search with gated value read.
module rcb_lookup #(
  parameter int ENTRIES = 64,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 6,
  parameter int LOG_W   = 5
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           userMode,
  input  logic [LOG_W-1:0]               lkLog,
  input  logic [ENTRIES-1:0][LOG_W-1:0]  tagArr,
  input  logic [ENTRIES-1:0]             mrBits,
  input  logic [ENTRIES-1:0]             privBits,
  input  logic [ENTRIES-1:0]             rdyBits,
  input  logic [ENTRIES-1:0][DATA_W-1:0] valArr,
  output logic                           hit,
  output logic [IDX_W-1:0]               idx,
  output logic                           rdyOut,
  output logic [DATA_W-1:0]              data
);

  logic [ENTRIES-1:0] cmpEn;
  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] readLine;
  logic [IDX_W-1:0]   idxNext;
  logic [DATA_W-1:0]  dataNext;

  // Comparator enable: newest mapping only, and not privileged in user mode
  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      cmpEn[e]    = mrBits[e] & (~privBits[e] | ~userMode);
      match[e]    = cmpEn[e] && (tagArr[e] == lkLog);
      readLine[e] = match[e] & rdyBits[e];
    end
  end

  // At most one match: OR-encode the index and the gated read
  always_comb begin
    idxNext  = '0;
    dataNext = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match[e])    idxNext  = idxNext | IDX_W'(e);
      if (readLine[e]) dataNext = dataNext | valArr[e];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hit    <= 1'b0;
      idx    <= '0;
      rdyOut <= 1'b0;
      data   <= '0;
    end else begin
      hit    <= |match;
      idx    <= idxNext;
      rdyOut <= |readLine;
      if (|readLine) data <= dataNext;
    end
  end

endmodule

// File: rtl/rcb_ctrl.sv
// Free pool and allocate/free/writeback strobes.
module rcb_ctrl
  import rcb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic             freeValid,
  input  logic [IDX_W-1:0] freeIdx,
  input  logic             wbValid,
  output logic             allocReady,
  output logic [IDX_W-1:0] allocIdx,
  output cb_strobe_t       strobe
);

  logic [ENTRIES-1:0] freeMask;
  logic               found;

  // Lowest-numbered free entry
  always_comb begin
    found    = 1'b0;
    allocIdx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (freeMask[e] && !found) begin
        allocIdx = IDX_W'(e);
        found    = 1'b1;
      end
    end
  end

  assign allocReady     = found;
  assign strobe.allocEn = allocValid & found;
  assign strobe.freeEn  = freeValid;
  assign strobe.wbEn    = wbValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeMask <= '1;
    end else begin
      if (strobe.allocEn) freeMask[allocIdx] <= 1'b0;
      if (strobe.freeEn)  freeMask[freeIdx]  <= 1'b1;
    end
  end

endmodule

// File: rtl/rcb_datapath.sv
// Entry tags, value array and the read ports.
module rcb_datapath
  import rcb_pkg::*;
#(
  parameter int ENTRIES    = 64,
  parameter int USER_REGS  = 15,
  parameter int DATA_W     = 32,
  parameter int READ_PORTS = 2,
  parameter int IDX_W      = 6,
  parameter int LOG_W      = 5
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  cb_strobe_t                        strobe,
  input  logic [IDX_W-1:0]                  allocIdx,
  input  logic [LOG_W-1:0]                  allocLog,
  input  logic [IDX_W-1:0]                  freeIdx,
  input  logic [IDX_W-1:0]                  wbIdx,
  input  logic [DATA_W-1:0]                 wbData,
  input  logic                              userMode,
  input  logic [READ_PORTS-1:0][LOG_W-1:0]  lkLog,
  output logic [READ_PORTS-1:0]             lkHit,
  output logic [READ_PORTS-1:0][IDX_W-1:0]  lkIdx,
  output logic [READ_PORTS-1:0]             lkRdy,
  output logic [READ_PORTS-1:0][DATA_W-1:0] lkData
);

  logic [ENTRIES-1:0][LOG_W-1:0]  tagArr;
  logic [ENTRIES-1:0]             mrBits;
  logic [ENTRIES-1:0]             privBits;
  logic [ENTRIES-1:0]             rdyBits;
  logic [ENTRIES-1:0][DATA_W-1:0] valArr;
  logic                           allocPriv;

  assign allocPriv = (allocLog >= LOG_W'(USER_REGS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagArr   <= '0;
      mrBits   <= '0;
      privBits <= '0;
      rdyBits  <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (strobe.wbEn && wbIdx == IDX_W'(e)) rdyBits[e] <= 1'b1;
        if (strobe.allocEn && mrBits[e] && tagArr[e] == allocLog)
          mrBits[e] <= 1'b0;
        if (strobe.freeEn && freeIdx == IDX_W'(e)) mrBits[e] <= 1'b0;
        if (strobe.allocEn && allocIdx == IDX_W'(e)) begin
          tagArr[e]   <= allocLog;
          mrBits[e]   <= 1'b1;
          privBits[e] <= allocPriv;
          rdyBits[e]  <= 1'b0;
        end
      end
    end
  end

  // Result values land directly in their entry
  always_ff @(posedge clk) begin
    if (strobe.wbEn) valArr[wbIdx] <= wbData;
  end

  for (genvar p = 0; p < READ_PORTS; p++) begin : g_port
    rcb_lookup #(
      .ENTRIES(ENTRIES), .DATA_W(DATA_W), .IDX_W(IDX_W), .LOG_W(LOG_W)
    ) u_lk (
      .clk(clk), .rstN(rstN), .userMode(userMode), .lkLog(lkLog[p]),
      .tagArr(tagArr), .mrBits(mrBits), .privBits(privBits),
      .rdyBits(rdyBits), .valArr(valArr),
      .hit(lkHit[p]), .idx(lkIdx[p]), .rdyOut(lkRdy[p]), .data(lkData[p])
    );
  end

endmodule

// File: rtl/rename_cbuf.sv
module rename_cbuf
  import rcb_pkg::*;
#(
  parameter int ENTRIES    = 64,
  parameter int LOGICAL    = 32,
  parameter int USER_REGS  = 15,
  parameter int DATA_W     = 32,
  parameter int READ_PORTS = 2,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int LOG_W     = $clog2(LOGICAL)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              allocValid,
  input  logic [LOG_W-1:0]                  allocLog,
  output logic                              allocReady,
  output logic [IDX_W-1:0]                  allocIdx,
  input  logic                              wbValid,
  input  logic [IDX_W-1:0]                  wbIdx,
  input  logic [DATA_W-1:0]                 wbData,
  input  logic                              freeValid,
  input  logic [IDX_W-1:0]                  freeIdx,
  input  logic                              userMode,
  input  logic [READ_PORTS-1:0][LOG_W-1:0]  lkLog,
  output logic [READ_PORTS-1:0]             lkHit,
  output logic [READ_PORTS-1:0][IDX_W-1:0]  lkIdx,
  output logic [READ_PORTS-1:0]             lkRdy,
  output logic [READ_PORTS-1:0][DATA_W-1:0] lkData
);

  cb_strobe_t strobe;

  rcb_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .freeValid(freeValid),
    .freeIdx(freeIdx), .wbValid(wbValid), .allocReady(allocReady),
    .allocIdx(allocIdx), .strobe(strobe)
  );

  rcb_datapath #(
    .ENTRIES(ENTRIES), .USER_REGS(USER_REGS), .DATA_W(DATA_W),
    .READ_PORTS(READ_PORTS), .IDX_W(IDX_W), .LOG_W(LOG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .allocIdx(allocIdx),
    .allocLog(allocLog), .freeIdx(freeIdx), .wbIdx(wbIdx), .wbData(wbData),
    .userMode(userMode), .lkLog(lkLog), .lkHit(lkHit), .lkIdx(lkIdx),
    .lkRdy(lkRdy), .lkData(lkData)
  );

endmodule

// File: rtl/rename_cbuf_chk.sv
module rename_cbuf_chk #(
  parameter int ENTRIES    = 64,
  parameter int LOGICAL    = 32,
  parameter int USER_REGS  = 15,
  parameter int DATA_W     = 32,
  parameter int READ_PORTS = 2,
  localparam int LOG_W     = $clog2(LOGICAL)
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              allocReady,
  input logic                              freeValid,
  input logic                              userMode,
  input logic [READ_PORTS-1:0][LOG_W-1:0]  lkLog,
  input logic [READ_PORTS-1:0]             lkHit,
  input logic [READ_PORTS-1:0]             lkRdy,
  input logic [READ_PORTS-1:0][DATA_W-1:0] lkData
);

  // R1: pool is full of free entries on leaving reset
  p_reset_ready_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> allocReady);

  // R7: an empty pool stays empty until something is freed
  p_full_stays_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!allocReady && !freeValid) |=> !allocReady);

  // R8: a free always leaves a free entry behind
  p_free_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    freeValid |=> allocReady);

  for (genvar p = 0; p < READ_PORTS; p++) begin : g_chk
    // R6: data moves only on a ready hit
    p_data_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      !(lkHit[p] && lkRdy[p]) |-> $stable(lkData[p]));

    // R9: ready is never reported without a hit
    p_rdy_hit_r9: assert property (@(posedge clk) disable iff (!rstN)
      lkRdy[p] |-> lkHit[p]);

    // R5: user-mode search never reaches banked registers
    p_user_priv_r5: assert property (@(posedge clk) disable iff (!rstN)
      ($past(userMode) && ($past(lkLog[p]) >= LOG_W'(USER_REGS))) |-> !lkHit[p]);
  end

endmodule

bind rename_cbuf rename_cbuf_chk #(
  .ENTRIES(ENTRIES), .LOGICAL(LOGICAL), .USER_REGS(USER_REGS),
  .DATA_W(DATA_W), .READ_PORTS(READ_PORTS)
) u_chk (
  .clk(clk), .rstN(rstN), .allocReady(allocReady), .freeValid(freeValid),
  .userMode(userMode), .lkLog(lkLog), .lkHit(lkHit), .lkRdy(lkRdy),
  .lkData(lkData)
);

// File: tb/sim_rename_cbuf.sv
`timescale 1ns/1ps
module sim_rename_cbuf;

  localparam int NE = 64;
  localparam int NP = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid = 1'b0;
  logic [4:0] allocLog = '0;
  logic allocReady;
  logic [5:0] allocIdx;
  logic wbValid = 1'b0;
  logic [5:0] wbIdx = '0;
  logic [31:0] wbData = '0;
  logic freeValid = 1'b0;
  logic [5:0] freeIdx = '0;
  logic userMode = 1'b0;
  logic [NP-1:0][4:0] lkLog = '0;
  logic [NP-1:0] lkHit;
  logic [NP-1:0][5:0] lkIdx;
  logic [NP-1:0] lkRdy;
  logic [NP-1:0][31:0] lkData;

  always #2.5 clk = ~clk;

  rename_cbuf u0 (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocLog(allocLog),
    .allocReady(allocReady), .allocIdx(allocIdx), .wbValid(wbValid),
    .wbIdx(wbIdx), .wbData(wbData), .freeValid(freeValid), .freeIdx(freeIdx),
    .userMode(userMode), .lkLog(lkLog), .lkHit(lkHit), .lkIdx(lkIdx),
    .lkRdy(lkRdy), .lkData(lkData)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Behavioural map table
  logic [4:0]  mLog  [NE];
  bit          mMr   [NE];
  bit          mPriv [NE];
  bit          mRdy  [NE];
  bit          mFree [NE];
  logic [31:0] mVal  [NE];
  logic [31:0] lastData [NP];

  // Scoreboard queues
  bit          qHit  [$];
  logic [5:0]  qIdx  [$];
  bit          qRdy  [$];
  logic [31:0] qData [$];
  int          qPort [$];
  string       qReq  [$];
  string curReq = "R1";

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int lowestFree();
    for (int e = 0; e < NE; e++) if (mFree[e]) return e;
    return -1;
  endfunction

  // Driver: one cycle of stimulus, expectations pushed before model update
  task automatic step(bit aV, logic [4:0] aL, bit wV, logic [5:0] wI,
                      logic [31:0] wD, bit fV, logic [5:0] fI, bit um,
                      logic [4:0] l0, logic [4:0] l1);
    int lf;
    @(negedge clk);
    allocValid = aV; allocLog = aL; wbValid = wV; wbIdx = wI; wbData = wD;
    freeValid = fV; freeIdx = fI; userMode = um; lkLog[0] = l0; lkLog[1] = l1;
    for (int p = 0; p < NP; p++) begin
      bit h; bit r; logic [5:0] ix; logic [31:0] d; logic [4:0] L;
      L = (p == 0) ? l0 : l1;
      h = 0; ix = 0;
      for (int e = 0; e < NE; e++)
        if (mMr[e] && (!um || !mPriv[e]) && mLog[e] == L) begin
          h = 1; ix = 6'(e);
        end
      r = h && mRdy[ix];
      d = r ? mVal[ix] : lastData[p];
      lastData[p] = d;
      qHit.push_back(h); qIdx.push_back(ix); qRdy.push_back(r);
      qData.push_back(d); qPort.push_back(p); qReq.push_back(curReq);
    end
    lf = lowestFree();
    chk({curReq, " allocReady"}, 64'(allocReady), 64'(lf >= 0));
    if (aV && lf >= 0) chk({curReq, " allocIdx"}, 64'(allocIdx), 64'(lf));
    // model update
    if (wV) begin mRdy[wI] = 1; mVal[wI] = wD; end
    if (aV && lf >= 0)
      for (int e = 0; e < NE; e++) if (mMr[e] && mLog[e] == aL) mMr[e] = 0;
    if (fV) begin mMr[fI] = 0; mFree[fI] = 1; end
    if (aV && lf >= 0) begin
      mLog[lf] = aL; mMr[lf] = 1; mPriv[lf] = (aL >= 15);
      mRdy[lf] = 0; mFree[lf] = 0;
    end
  endtask

  task automatic idle(bit um, logic [4:0] l0, logic [4:0] l1);
    step(0, 0, 0, 0, 0, 0, 0, um, l0, l1);
  endtask

  // Monitor: compare results one step after they were pushed
  always @(posedge clk) begin
    #1;
    while (qHit.size() > 0) begin
      bit h; logic [5:0] ix; bit r; logic [31:0] d; int p; string rq;
      h = qHit.pop_front(); ix = qIdx.pop_front(); r = qRdy.pop_front();
      d = qData.pop_front(); p = qPort.pop_front(); rq = qReq.pop_front();
      checks++;
      if (lkHit[p] !== h || (h && lkIdx[p] !== ix) || lkRdy[p] !== r ||
          lkData[p] !== d) begin
        fails++;
        $display("FAIL %s port%0d: hit=%0b idx=%0d rdy=%0b data=%h expected hit=%0b idx=%0d rdy=%0b data=%h",
                 rq, p, lkHit[p], lkIdx[p], lkRdy[p], lkData[p], h, ix, r, d);
      end
    end
  end

  initial begin
    for (int e = 0; e < NE; e++) begin
      mLog[e] = 0; mMr[e] = 0; mPriv[e] = 0; mRdy[e] = 0; mFree[e] = 1;
      mVal[e] = 0;
    end
    for (int p = 0; p < NP; p++) lastData[p] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 and R9: empty buffer misses everything
    curReq = "R1";
    chk("R1 allocReady", 64'(allocReady), 64'd1);
    chk("R1 allocIdx", 64'(allocIdx), 64'd0);
    idle(0, 3, 20);
    curReq = "R9";
    idle(1, 0, 31);

    // R2: allocate register 3 into entry 0, then look it up
    curReq = "R2";
    step(1, 3, 0, 0, 0, 0, 0, 0, 7, 7);
    idle(0, 3, 3);

    // R10 and R3: rename 3 again while looking it up
    curReq = "R10";
    step(1, 3, 0, 0, 0, 0, 0, 0, 3, 3);
    curReq = "R3";
    idle(0, 3, 3);

    // R4: out-of-order writebacks, entry 1 before entry 0
    curReq = "R4";
    step(0, 0, 1, 1, 32'hA1A1_0001, 0, 0, 0, 3, 3);
    step(0, 0, 1, 0, 32'hB0B0_0000, 0, 0, 0, 3, 3);
    idle(0, 3, 3);

    // R5: banked register 20 in entry 2
    curReq = "R5";
    step(1, 20, 0, 0, 0, 0, 0, 0, 3, 3);
    step(0, 0, 1, 2, 32'hC2C2_0002, 0, 0, 0, 20, 3);
    idle(1, 20, 3);
    idle(0, 20, 3);
    idle(1, 3, 20);

    // R6: not-ready hit keeps old data; R10 writeback in the lookup cycle
    curReq = "R6";
    step(1, 5, 0, 0, 0, 0, 0, 0, 3, 20);
    idle(0, 5, 5);
    curReq = "R10";
    step(0, 0, 1, 3, 32'hD3D3_0003, 0, 0, 0, 5, 5);
    curReq = "R4";
    idle(0, 5, 5);

    // R7: fill the pool, then an ignored request
    curReq = "R7";
    while (lowestFree() >= 0) step(1, 5'(8 + (lowestFree() % 7)), 0, 0, 0, 0, 0, 0, 3, 5);
    step(1, 3, 0, 0, 0, 0, 0, 0, 3, 5);
    idle(0, 3, 5);
    idle(0, 3, 5);

    // R8: free stale entry 0, then the newest mapping of 5 (entry 3)
    curReq = "R8";
    step(0, 0, 0, 0, 0, 1, 0, 0, 3, 5);
    idle(0, 3, 5);
    step(0, 0, 0, 0, 0, 1, 3, 0, 3, 5);
    idle(0, 5, 3);
    idle(0, 5, 3);

    // R3 and R10: mixed random traffic on every cycle
    curReq = "R3";
    begin
      logic [31:0] lf = 32'h1ACE_B00C;
      for (int i = 0; i < 3000; i++) begin
        bit aV; bit wV; bit fV; logic [5:0] wI; logic [5:0] fI;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        wI = lf[13:8]; fI = lf[19:14];
        aV = lf[0];
        wV = lf[1] && !mFree[wI];
        fV = lf[2] && !mFree[fI] && !mMr[fI];
        step(aV, lf[24:20], wV, wI, lf ^ 32'h5A5A_0000, fV, fI, lf[3],
             lf[29:25], {lf[4], lf[7:4]});
      end
    end
    idle(0, 0, 0);
    idle(0, 0, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule